// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block holds a set of management statistics counters for an Ethernet MAC. Frame status logic elsewhere raises one single-cycle event pulse per counter. Each pulse adds one to its own counter. Software reads a counter by presenting an index with a read strobe. The value comes back one clock later. When the clear-on-read option is on, that read also empties the counter.

Each counter saturates at its largest value rather than wrapping. When a counter crosses the midpoint of its range, it latches a sticky half-full status bit. A per-counter enable mask selects which of these bits reach the single combined interrupt output. A global clear input empties every counter and every status bit at once. A clear that arrives together with an event always keeps that event.

Top module: `ethstat_bank`

## Requirements
- R1: After reset, every counter reads 0, every half-full status bit is 0 and the interrupt is low.
- R2: A high `evtPulse[i]` at a rising edge adds one to counter i only. Several counters can count at the same edge, each independently.
- R3: A read strobe at a rising edge loads `rdData` with the addressed counter's value from before that edge, so the value is visible one clock after the strobe. While the strobe is low, `rdData` holds. An index of `NUM_CTR` or above reads 0 and changes no counter.
- R4: With `clrOnRead` high, a read returns the counter's value and sets it to 0 at the same edge. With `clrOnRead` low, a read leaves the counter unchanged.
- R5: If a clear (by read or global) and an event for the same counter fall on the same edge, the counter becomes 1.
- R6: A counter saturates at 2^CTR_W-1. Further events leave it at that value, and it never wraps to a smaller value.
- R7: `halfStat[i]` goes high at the edge where counter i steps from 2^(CTR_W-1)-1 to 2^(CTR_W-1).
- R8: A half-full status bit is sticky. It clears only when a one is written to `halfAck[i]` or when its counter is cleared. Increments above the midpoint do not set it again. A setting step wins over an acknowledge at the same edge.
- R9: `irq` is high exactly when some half-full bit is set and its `intEn` bit is 1. Masked status bits leave `irq` low.
- R10: A one-cycle `globalClr` sets every counter and every half-full bit to 0. An event at that edge leaves its counter at 1 (R5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtPulse | input | NUM_CTR | One increment pulse per counter |
| rdStrobe | input | 1 | Read request for the counter at `rdAddr` |
| rdAddr | input | ADDR_W | Counter index to read |
| clrOnRead | input | 1 | When high, reads empty the addressed counter |
| intEn | input | NUM_CTR | Interrupt enable per half-full bit |
| halfAck | input | NUM_CTR | Write-one-to-clear for half-full bits |
| globalClr | input | 1 | Write-one clear of all counters and status |
| rdData | output | CTR_W | Registered read value |
| halfStat | output | NUM_CTR | Sticky half-full status per counter |
| irq | output | 1 | Combined half-full interrupt |

## Verification
The hardest cases to produce are the midpoint and saturation boundaries, because reaching them with full 32-bit counters would take billions of events. The bench therefore sets the counter width to five bits. With that width a counter reaches its midpoint after 16 events and saturates at 31. The same-edge collisions (clear-on-read with an event, and acknowledge with the step that sets a status bit) are also hard to produce. The bench drives both inputs at the same falling edge, so both are seen at one rising edge.

// File: rtl/ethstat_pkg.sv
package ethstat_pkg;

  // strobes passed from control decode to the counter datapath
  typedef struct packed {
    logic rdLoad;   // capture a read value this edge
    logic rdClear;  // empty the addressed counter this edge
    logic clrAll;   // empty every counter and status bit
  } ctlStrobe_t;

endpackage

// File: rtl/ethstat_ctrl.sv
module ethstat_ctrl
  import ethstat_pkg::*;
#(
  parameter int NUM_CTR = 47,
  parameter int ADDR_W  = 6
) (
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              clrOnRead,
  input  logic              globalClr,
  output ctlStrobe_t        strobes
);

  logic addrInRange;

  always_comb begin
    addrInRange     = (32'(rdAddr) < 32'(NUM_CTR));
    strobes.rdLoad  = rdStrobe;
    strobes.rdClear = rdStrobe && clrOnRead && addrInRange;
    strobes.clrAll  = globalClr;
  end

endmodule

// File: rtl/ethstat_dp.sv
module ethstat_dp
  import ethstat_pkg::*;
#(
  parameter int NUM_CTR = 47,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctlStrobe_t               strobes,
  input  logic [ADDR_W-1:0]        rdAddr,
  input  logic [NUM_CTR-1:0]       evtPulse,
  input  logic [NUM_CTR-1:0]       halfAck,
  output logic [CTR_W-1:0]         rdData,
  output logic [NUM_CTR-1:0]       halfStat,
  output logic [NUM_CTR*CTR_W-1:0] cntFlat
);

  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_HALF = {1'b1, {(CTR_W-1){1'b0}}};
  localparam logic [CTR_W-1:0] CTR_PRE  = CTR_HALF - 1'b1;

  for (genvar i = 0; i < NUM_CTR; i++) begin : gCtr
    logic [CTR_W-1:0] cntQ;
    logic             halfQ;
    logic             clrHit;
    logic             incHit;
    logic             halfHit;

    assign clrHit  = strobes.clrAll || (strobes.rdClear && (rdAddr == ADDR_W'(i)));
    assign incHit  = evtPulse[i] && (cntQ != CTR_MAX);
    assign halfHit = evtPulse[i] && !clrHit && (cntQ == CTR_PRE);

    // a clear keeps a coincident event: the counter restarts at one
    always_ff @(posedge clk) begin
      if (!rst_n)      cntQ <= '0;
      else if (clrHit) cntQ <= CTR_W'(evtPulse[i]);
      else if (incHit) cntQ <= cntQ + 1'b1;
    end

    // sticky status; a setting step wins over an acknowledge
    always_ff @(posedge clk) begin
      if (!rst_n)                    halfQ <= 1'b0;
      else if (halfHit)              halfQ <= 1'b1;
      else if (clrHit || halfAck[i]) halfQ <= 1'b0;
    end

    assign cntFlat[i*CTR_W +: CTR_W] = cntQ;
    assign halfStat[i]               = halfQ;
  end

  logic [CTR_W-1:0] rdSel;

  always_comb begin
    rdSel = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (rdAddr == ADDR_W'(k)) rdSel = cntFlat[k*CTR_W +: CTR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              rdData <= '0;
    else if (strobes.rdLoad) rdData <= rdSel;
  end

endmodule

// File: rtl/ethstat_bank.sv
module ethstat_bank
  import ethstat_pkg::*;
#(
  parameter int NUM_CTR = 47,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] evtPulse,
  input  logic               rdStrobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               clrOnRead,
  input  logic [NUM_CTR-1:0] intEn,
  input  logic [NUM_CTR-1:0] halfAck,
  input  logic               globalClr,
  output logic [CTR_W-1:0]   rdData,
  output logic [NUM_CTR-1:0] halfStat,
  output logic               irq
);

  ctlStrobe_t               strobes;
  logic [NUM_CTR*CTR_W-1:0] cntFlat;

  ethstat_ctrl #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) uCtrl (
    .rdStrobe (rdStrobe),
    .rdAddr   (rdAddr),
    .clrOnRead(clrOnRead),
    .globalClr(globalClr),
    .strobes  (strobes)
  );

  ethstat_dp #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) uDp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .rdAddr  (rdAddr),
    .evtPulse(evtPulse),
    .halfAck (halfAck),
    .rdData  (rdData),
    .halfStat(halfStat),
    .cntFlat (cntFlat)
  );

  assign irq = |(halfStat & intEn);

endmodule

// File: rtl/ethstat_bank_chk.sv
module ethstat_bank_chk #(
  parameter int NUM_CTR = 47,
  parameter int CTR_W   = 32,
  parameter int ADDR_W  = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     rdStrobe,
  input logic                     clrOnRead,
  input logic                     globalClr,
  input logic [NUM_CTR-1:0]       intEn,
  input logic [NUM_CTR-1:0]       halfAck,
  input logic [CTR_W-1:0]         rdData,
  input logic [NUM_CTR-1:0]       halfStat,
  input logic                     irq,
  input logic [NUM_CTR*CTR_W-1:0] cntFlat
);

  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  logic anyClear;
  assign anyClear = globalClr || (rdStrobe && clrOnRead);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStrobe |=> $stable(rdData)); // R3

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halfAck == '0 && !anyClear) |=> ((halfStat & $past(halfStat)) == $past(halfStat))); // R8

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (intEn == '0) |-> !irq); // R9

  for (genvar i = 0; i < NUM_CTR; i++) begin : gChk
    logic [CTR_W-1:0] cnt;
    assign cnt = cntFlat[i*CTR_W +: CTR_W];

    AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
      !anyClear |=> (cnt >= $past(cnt))); // R6

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CTR_MAX && !anyClear) |=> (cnt == CTR_MAX)); // R6

    AST_GLOBAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      globalClr |=> (cnt <= CTR_W'(1))); // R10
  end

endmodule

bind ethstat_bank ethstat_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rdStrobe (rdStrobe),
  .clrOnRead(clrOnRead),
  .globalClr(globalClr),
  .intEn    (intEn),
  .halfAck  (halfAck),
  .rdData   (rdData),
  .halfStat (halfStat),
  .irq      (irq),
  .cntFlat  (cntFlat)
);

// File: tb/ethstat_bank_test.sv
module ethstat_bank_test;

  localparam int NUM_CTR = 47;
  localparam int CTR_W   = 5;
  localparam int ADDR_W  = 6;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_CTR-1:0] evtPulse;
  logic               rdStrobe;
  logic [ADDR_W-1:0]  rdAddr;
  logic               clrOnRead;
  logic [NUM_CTR-1:0] intEn;
  logic [NUM_CTR-1:0] halfAck;
  logic               globalClr;
  logic [CTR_W-1:0]   rdData;
  logic [NUM_CTR-1:0] halfStat;
  logic               irq;

  int vectors = 0;
  int miscompares = 0;

  ethstat_bank #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .rdStrobe(rdStrobe),
    .rdAddr(rdAddr), .clrOnRead(clrOnRead), .intEn(intEn), .halfAck(halfAck),
    .globalClr(globalClr), .rdData(rdData), .halfStat(halfStat), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int idx, input int n);
    evtPulse[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic readCtr(input int addr, output int val);
    rdAddr   = ADDR_W'(addr);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    val = int'(rdData);
  endtask

  task automatic ack(input int idx);
    halfAck[idx] = 1'b1;
    @(negedge clk);
    halfAck = '0;
  endtask

  task automatic tReset;
    int v;
    check("R1 halfStat", int'(halfStat != '0), 0);
    check("R1 irq", int'(irq), 0);
    readCtr(5, v); check("R1 counter 5", v, 0);
  endtask

  task automatic tCount;
    int v;
    pulse(3, 7);
    readCtr(3, v); check("R2 counter 3", v, 7);
    readCtr(3, v); check("R4 read without clear", v, 7);
    evtPulse[3] = 1'b1; evtPulse[10] = 1'b1;
    repeat (3) @(negedge clk);
    evtPulse = '0;
    readCtr(3, v);  check("R2 simultaneous counter 3", v, 10);
    readCtr(10, v); check("R2 simultaneous counter 10", v, 3);
  endtask

  task automatic tReadHold;
    int v;
    pulse(10, 2);
    check("R3 rdData holds without strobe", int'(rdData), 3);
    readCtr(10, v); check("R3 new value after strobe", v, 5);
    clrOnRead = 1'b1;
    readCtr(47, v); check("R3 out-of-range reads zero", v, 0);
    clrOnRead = 1'b0;
    readCtr(10, v); check("R3 out-of-range changes nothing", v, 5);
  endtask

  task automatic tClearRead;
    int v;
    clrOnRead = 1'b1;
    readCtr(3, v); check("R4 clear-on-read returns value", v, 10);
    readCtr(3, v); check("R4 counter emptied", v, 0);
    clrOnRead = 1'b0;
  endtask

  task automatic tCoincide;
    int v;
    pulse(7, 4);
    clrOnRead = 1'b1;
    evtPulse[7] = 1'b1;
    readCtr(7, v);
    evtPulse = '0;
    check("R5 read value at collision", v, 4);
    readCtr(7, v); check("R5 event kept through clear", v, 1);
    clrOnRead = 1'b0;
  endtask

  task automatic tHalf;
    intEn[12] = 1'b1;
    pulse(12, 15);
    check("R7 below midpoint", int'(halfStat[12]), 0);
    check("R9 irq below midpoint", int'(irq), 0);
    pulse(12, 1);
    check("R7 midpoint sets status", int'(halfStat[12]), 1);
    check("R9 enabled status raises irq", int'(irq), 1);
    ack(12);
    check("R8 write-one clears status", int'(halfStat[12]), 0);
    check("R9 irq drops after ack", int'(irq), 0);
    pulse(12, 3);
    check("R8 no re-set above midpoint", int'(halfStat[12]), 0);
  endtask

  task automatic tMaskSat;
    int v;
    pulse(20, 16);
    check("R7 counter 20 status", int'(halfStat[20]), 1);
    check("R9 masked status keeps irq low", int'(irq), 0);
    pulse(20, 4);
    check("R8 status sticky", int'(halfStat[20]), 1);
    pulse(20, 20);
    readCtr(20, v); check("R6 saturates at max", v, 31);
  endtask

  task automatic tSetWins;
    int v;
    pulse(25, 15);
    evtPulse[25] = 1'b1;
    halfAck[25]  = 1'b1;
    @(negedge clk);
    evtPulse = '0; halfAck = '0;
    check("R8 set wins over ack", int'(halfStat[25]), 1);
    clrOnRead = 1'b1;
    readCtr(25, v); check("R4 clear-on-read value 25", v, 16);
    check("R8 counter clear drops status", int'(halfStat[25]), 0);
    clrOnRead = 1'b0;
  endtask

  task automatic tGlobal;
    int v;
    pulse(5, 3);
    globalClr   = 1'b1;
    evtPulse[9] = 1'b1;
    @(negedge clk);
    globalClr = 1'b0; evtPulse = '0;
    check("R10 status cleared", int'(halfStat != '0), 0);
    readCtr(20, v); check("R10 counter 20 emptied", v, 0);
    readCtr(5, v);  check("R10 counter 5 emptied", v, 0);
    readCtr(9, v);  check("R10 coincident event kept", v, 1);
    readCtr(12, v); check("R10 counter 12 emptied", v, 0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; evtPulse = '0; rdStrobe = 1'b0; rdAddr = '0;
    clrOnRead = 1'b0; intEn = '0; halfAck = '0; globalClr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tCount();
    tReadHold();
    tClearRead();
    tCoincide();
    tHalf();
    tMaskSat();
    tSetWins();
    tGlobal();
    summary();
    $finish;
  end

endmodule